// File: doc/BRIEF.md
# Timing Reference Mode Controller

This controller decides how a digital clock synchronizer steers its output frequency. It picks one of three operating modes: free-run, in which the local calibrated oscillator drives the outputs; locked, in which the loop acquires and then tracks one input reference; and holdover, in which the loop replays a stored frequency history. In every mode it keeps watching a set of per-reference valid flags, a lock-detect line from the loop, and the history-ready line from the history filter.

Software can choose automatic or manual operation. It can also force holdover or free-run through two request bits. In automatic operation the controller picks the lowest-numbered valid reference. When the tracked reference fails and another one is valid, it moves to that reference. Holdover is entered automatically only when no valid reference is left. In manual operation the controller tracks the reference index software supplies, and never enters holdover by itself. The controller tells the loop which frequency source to use. While in holdover it reports the whole seconds elapsed since holdover began.

Top module: `ref_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset: mode is free-run (mode code 0), the locked and loss-of-lock flags are low, the selected index is 0, the holdover seconds counter is 0 and the frequency source is 0.
- R2: Mode codes: 0 = free-run, 1 = locked (acquiring or tracking), 2 = holdover. In automatic operation with no force request, free-run or holdover moves to locked mode one cycle after any reference flag is set, selecting the lowest-index valid reference with the locked flag low. With no valid reference, free-run persists.
- R3: In automatic operation, if the selected reference becomes invalid while another is valid, the next cycle selects the lowest-index valid reference, stays in locked mode, and clears the locked flag (acquisition restarts).
- R4: The locked flag rises one cycle after lock-detect is seen high, provided the block was already in locked mode on the same reference and that reference is valid. It never rises on the cycle a reference is first selected.
- R5: If the locked flag is high (or loss-of-lock is already high) and lock-detect is low or the tracked reference is invalid while the block stays on the same reference in locked mode, loss-of-lock goes high and locked goes low on the next cycle. Loss-of-lock clears on relock, on a reference change and on leaving locked mode.
- R6: In automatic operation, if the selected reference is lost and no reference is valid, holdover (mode 2) is entered on the next cycle.
- R7: The holdover seconds counter is 0 on the cycle after holdover entry. It adds one for each cycle in holdover with the seconds strobe high, stops at its all-ones maximum, and reads 0 outside holdover.
- R8: The frequency source code is 0 (local oscillator) in free-run and 1 (reference) in locked mode. In holdover it is 2 (stored history) while history-ready is high and 3 (keep prior frequency) while it is low.
- R9: A holdover force request moves the block to holdover on the next cycle from any mode, whatever the reference flags. A free-run force request takes priority over it and moves the block to free-run.
- R10: In manual operation with no force request, the block goes to locked mode on the software reference index the next cycle and never enters holdover by itself. A change of the index restarts acquisition. Loss of that reference keeps locked mode, with locked low and loss-of-lock raised if lock had been held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ok | input | NREF | Per-reference valid flags |
| lock_det | input | 1 | Lock indication from the loop |
| auto_en | input | 1 | 1 = automatic selection, 0 = manual |
| man_ref | input | $clog2(NREF) | Reference index used in manual operation |
| force_hold | input | 1 | Request holdover |
| force_free | input | 1 | Request free-run (overrides force_hold) |
| hist_avail | input | 1 | Holdover history is usable |
| sec_tick | input | 1 | One-cycle strobe once per second |
| mode | output | 2 | Operating mode code |
| locked | output | 1 | Lock achieved on the selected reference |
| lol | output | 1 | Loss-of-lock flag |
| sel_ref | output | $clog2(NREF) | Selected reference index |
| hold_secs | output | CNT_W | Seconds spent in holdover |
| freq_src | output | 2 | Frequency source for the loop |

## Verification
Mode, selected index, locked, loss-of-lock and the seconds counter are registered. Each settles exactly one clock edge after the inputs that cause it. The frequency source is decoded from the registered mode and the live history-ready input, so it follows that input within the same cycle. The bench changes inputs just after a rising edge. A behavioural model advances on the same edge, and the outputs are compared with it on the falling edge. Directed checks likewise read the outputs shortly after the edge that follows each stimulus.

// File: rtl/ref_mode_ctrl.sv
module ref_mode_ctrl #(
  parameter int NREF  = 4,
  parameter int CNT_W = 16,
  localparam int IW   = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  ref_ok,
  input  logic             lock_det,
  input  logic             auto_en,
  input  logic [IW-1:0]    man_ref,
  input  logic             force_hold,
  input  logic             force_free,
  input  logic             hist_avail,
  input  logic             sec_tick,
  output logic [1:0]       mode,
  output logic             locked,
  output logic             lol,
  output logic [IW-1:0]    sel_ref,
  output logic [CNT_W-1:0] hold_secs,
  output logic [1:0]       freq_src
);
  localparam logic [1:0] M_FREE = 2'd0, M_LOCK = 2'd1, M_HOLD = 2'd2;
  localparam logic [CNT_W-1:0] SEC_MAX = '1;

  logic [1:0]    mode_n;
  logic [IW-1:0] sel_n, low_idx;
  logic          any_ok, keep_ref, good;

  assign any_ok = |ref_ok;

  always_comb begin
    low_idx = '0;
    for (int i = NREF - 1; i >= 0; i--)
      if (ref_ok[i]) low_idx = IW'(i);
  end

  always_comb begin
    mode_n = mode;
    sel_n  = sel_ref;
    if (force_free)
      mode_n = M_FREE;
    else if (force_hold)
      mode_n = M_HOLD;
    else if (!auto_en) begin
      mode_n = M_LOCK;
      sel_n  = man_ref;
    end else begin
      case (mode)
        M_LOCK:
          if (!ref_ok[sel_ref]) begin
            if (any_ok) sel_n = low_idx;
            else        mode_n = M_HOLD;
          end
        M_FREE, M_HOLD:
          if (any_ok) begin
            mode_n = M_LOCK;
            sel_n  = low_idx;
          end
        default: mode_n = M_FREE;
      endcase
    end
  end

  assign keep_ref = (mode == M_LOCK) && (mode_n == M_LOCK) && (sel_n == sel_ref);
  assign good     = ref_ok[sel_ref] && lock_det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_FREE;
      sel_ref   <= '0;
      locked    <= 1'b0;
      lol       <= 1'b0;
      hold_secs <= '0;
    end else begin
      mode    <= mode_n;
      sel_ref <= sel_n;
      locked  <= keep_ref && good;
      lol     <= keep_ref && !good && (locked || lol);
      if (mode_n != M_HOLD || mode != M_HOLD)
        hold_secs <= '0;
      else if (sec_tick && hold_secs != SEC_MAX)
        hold_secs <= hold_secs + 1'b1;
    end
  end

  always_comb begin
    case (mode)
      M_LOCK:  freq_src = 2'd1;
      M_HOLD:  freq_src = hist_avail ? 2'd2 : 2'd3;
      default: freq_src = 2'd0;
    endcase
  end
endmodule

// File: rtl/ref_mode_ctrl_chk.sv
module ref_mode_ctrl_chk #(
  parameter int NREF  = 4,
  parameter int CNT_W = 16,
  localparam int IW   = (NREF > 1) ? $clog2(NREF) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREF-1:0]  ref_ok,
  input logic             lock_det,
  input logic             auto_en,
  input logic             force_hold,
  input logic             force_free,
  input logic [1:0]       mode,
  input logic             locked,
  input logic             lol,
  input logic [CNT_W-1:0] hold_secs
);
  assert_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !force_free && !force_hold && mode != 2'd1 && |ref_ok) |=> (mode == 2'd1 && !locked));

  assert_lock_needs_det_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !lock_det) |=> !locked);

  assert_lol_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && lol));

  assert_auto_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !force_free && !force_hold && mode == 2'd1 && ref_ok == '0) |=> mode == 2'd2);

  assert_hold_entry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |=> (mode != 2'd2 || hold_secs == '0));

  assert_force_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_free |=> mode == 2'd0);

  assert_force_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hold && !force_free) |=> mode == 2'd2);

  assert_manual_no_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !force_free && !force_hold) |=> mode == 2'd1);
endmodule

bind ref_mode_ctrl ref_mode_ctrl_chk #(.NREF(NREF), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_det(lock_det), .auto_en(auto_en),
  .force_hold(force_hold), .force_free(force_free), .mode(mode), .locked(locked),
  .lol(lol), .hold_secs(hold_secs)
);

// File: tb/ref_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module ref_mode_ctrl_tb_top;
  localparam int NREF = 4, CNT_W = 4, IW = 2;
  localparam int SMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic [NREF-1:0] ref_ok = '0;
  logic lock_det = 0, auto_en = 1, force_hold = 0, force_free = 0, hist_avail = 0, sec_tick = 0;
  logic [IW-1:0] man_ref = '0;
  logic [1:0] mode, freq_src;
  logic locked, lol;
  logic [IW-1:0] sel_ref;
  logic [CNT_W-1:0] hold_secs;

  int total = 0, bad = 0;
  bit done = 0;
  int m_mode = 0, m_sel = 0, m_lck = 0, m_lol = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  ref_mode_ctrl #(.NREF(NREF), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_det(lock_det), .auto_en(auto_en),
    .man_ref(man_ref), .force_hold(force_hold), .force_free(force_free),
    .hist_avail(hist_avail), .sec_tick(sec_tick), .mode(mode), .locked(locked),
    .lol(lol), .sel_ref(sel_ref), .hold_secs(hold_secs), .freq_src(freq_src)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest_ok();
    for (int i = 0; i < NREF; i++) if (ref_ok[i]) return i;
    return -1;
  endfunction

  // behavioural reference model, advanced on each rising edge
  always @(posedge clk) begin
    int nm, ns, lo, stay, ok;
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_lck = 0; m_lol = 0; m_cnt = 0;
    end else begin
      nm = m_mode; ns = m_sel; lo = lowest_ok();
      if (force_free) nm = 0;
      else if (force_hold) nm = 2;
      else if (!auto_en) begin nm = 1; ns = man_ref; end
      else if (m_mode == 1) begin
        if (!ref_ok[m_sel]) begin
          if (lo >= 0) ns = lo; else nm = 2;
        end
      end else if (lo >= 0) begin nm = 1; ns = lo; end
      stay = (m_mode == 1 && nm == 1 && ns == m_sel);
      ok = ref_ok[m_sel] && lock_det;
      m_lol = (stay && !ok && (m_lck || m_lol)) ? 1 : 0;
      m_lck = (stay && ok) ? 1 : 0;
      if (nm == 2 && m_mode == 2) begin
        if (sec_tick && m_cnt < SMAX) m_cnt++;
      end else m_cnt = 0;
      m_mode = nm; m_sel = ns;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 mode", mode, m_mode);
    chk("R3 sel_ref", sel_ref, m_sel);
    chk("R4 locked", locked, m_lck);
    chk("R5 lol", lol, m_lol);
    chk("R7 hold_secs", hold_secs, m_cnt);
    chk("R8 freq_src", freq_src, m_mode == 0 ? 0 : m_mode == 1 ? 1 : (hist_avail ? 2 : 3));
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 mode", mode, 0); chk("R1 locked", locked, 0); chk("R1 lol", lol, 0);
    chk("R1 sel", sel_ref, 0); chk("R1 secs", hold_secs, 0); chk("R1 src", freq_src, 0);
    rst_n = 1; tick(3);
    chk("R2 free-run persists", mode, 0);
    ref_ok = 4'b0110; tick();
    chk("R2 acquire mode", mode, 1); chk("R2 lowest sel", sel_ref, 1); chk("R2 not locked", locked, 0);
    lock_det = 1; tick();
    chk("R4 locked set", locked, 1);
    hist_avail = 1; tick(2);
    lock_det = 0; tick();
    chk("R5 lol raised", lol, 1); chk("R5 locked dropped", locked, 0);
    lock_det = 1; tick();
    chk("R5 lol cleared on relock", lol, 0); chk("R4 relocked", locked, 1);
    ref_ok = 4'b0100; tick();
    chk("R3 switch sel", sel_ref, 2); chk("R3 stays locked mode", mode, 1); chk("R3 locked cleared", locked, 0);
    tick(); chk("R4 locked on new ref", locked, 1);
    ref_ok = 4'b0000; tick();
    chk("R6 holdover", mode, 2); chk("R7 cleared", hold_secs, 0); chk("R8 history src", freq_src, 2);
    sec_tick = 1; tick(3); chk("R7 counting", hold_secs, 3);
    tick(17); sec_tick = 0; tick();
    chk("R7 saturated", hold_secs, SMAX);
    hist_avail = 0; #1; chk("R8 prior freq src", freq_src, 3);
    ref_ok = 4'b0001; tick();
    chk("R2 leave holdover", mode, 1); chk("R2 sel", sel_ref, 0); chk("R2 acq", locked, 0);
    chk("R7 zero outside", hold_secs, 0);
    tick(); chk("R4 locked again", locked, 1);
    force_hold = 1; tick(); chk("R9 forced hold", mode, 2);
    force_free = 1; tick(); chk("R9 free wins", mode, 0);
    force_free = 0; force_hold = 0; auto_en = 0; man_ref = 2'd3; ref_ok = 4'b0001; tick();
    chk("R10 manual mode", mode, 1); chk("R10 manual sel", sel_ref, 3);
    tick(); chk("R10 invalid ref no lock", locked, 0);
    ref_ok = 4'b1001; tick(); chk("R10 manual lock", locked, 1);
    ref_ok = 4'b0000; tick();
    chk("R10 no auto hold", mode, 1); chk("R10 lol", lol, 1); chk("R10 unlocked", locked, 0);
    man_ref = 2'd0; ref_ok = 4'b0001; tick();
    chk("R10 reselect", sel_ref, 0); chk("R10 lol clears", lol, 0);
    auto_en = 1;
    for (int k = 0; k < 3000; k++) begin
      ref_ok     = ($urandom % 4 == 0) ? NREF'($urandom) : ref_ok;
      lock_det   = ($urandom % 8) != 0;
      auto_en    = ($urandom % 50) != 0 ? auto_en : ~auto_en;
      man_ref    = IW'($urandom);
      force_hold = ($urandom % 40) == 0;
      force_free = ($urandom % 60) == 0;
      hist_avail = ($urandom % 3) != 0;
      sec_tick   = ($urandom % 2) == 0;
      tick();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule